// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit effective address for the indexed operand forms of a small processor. The decoder hands it a mode code, a base register selector and the raw offset field. The register file supplies the four base registers and the two 8-bit accumulators. One cycle after an accepted `start`, the block pulses `done` for one cycle. With that pulse it presents the address. For the auto-adjust forms it also presents the new base register value and a write-back strobe.

The two indirect forms work differently. Base plus offset does not give the operand address. It points at a 16-bit word in memory. The block fetches that word as two byte reads, high byte first, over a simple request/valid port. The fetched word then becomes the effective address. The block raises `done` only after the low byte has arrived. While a fetch is in progress, new `start` pulses are not accepted.

Top module: `idx_ea_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted start, the outputs `done`, `wb_en`, `illegal`, `indirect` and `mem_req` are all 0.
- R2: Constant modes: 0 takes `offset[4:0]` and 1 takes `offset[8:0]`, each sign-extended. Mode 2 takes all 16 bits. The address is base plus offset modulo 2^16, with `done`=1 exactly one cycle after the start is accepted.
- R3: `base_sel` encodes 0 = X, 1 = Y, 2 = SP and 3 = PC.
- R4: Pre-adjust modes are 6 (increment) and 7 (decrement), with step n = `offset[2:0]` + 1 (1 to 8). The address is base plus or minus n. `wb_en` is 1 and `wb_value` equals the address.
- R5: Post-adjust modes are 8 (increment) and 9 (decrement). The address is the unmodified base. `wb_en` is 1 and `wb_value` is base plus or minus n.
- R6: Accumulator modes: 3 adds A and 4 adds B, each zero-extended. Mode 5 adds D = {A,B}, with A as the high byte. All sums wrap modulo 2^16.
- R7: Two cases raise `illegal` together with `done` and keep `wb_en` at 0: any auto-adjust mode with PC as the base, and the unused mode codes 12 to 15.
- R8: Indirect modes are 10 (pointer = base + 16-bit offset) and 11 (pointer = base + D). From the cycle after the start, the block requests `mem_addr` = pointer and takes that byte as the high byte. It then requests pointer + 1 and takes that byte as the low byte. `done` and `indirect` are 1 in the cycle after the low byte is accepted, and `ea` = {high, low}.
- R9: While an indirect fetch is in progress, `start` is ignored. The request address and the final result do not change.
- R10: While `mem_req` is 1 and `mem_valid` is 0, the request stays asserted and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Indexed form code |
| base_sel | input | 2 | Base register selector |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| offset | input | 16 | Raw offset / step field |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| mem_req | output | 1 | Byte read request for the indirect pointer |
| mem_addr | output | 16 | Byte read address |
| mem_valid | input | 1 | Read data valid this cycle |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register write-back strobe |
| wb_value | output | 16 | New base register value |
| illegal | output | 1 | Disallowed mode/base combination |
| indirect | output | 1 | Indirect fetch in progress or just completed |

## Verification
Several behaviours are checked on every cycle. The post forms must present the base that was selected at start. The pre forms must write back exactly the address they produce. A PC base on an auto form must be flagged. The low-byte request must sit one above the high-byte request. `done` must follow the low byte. The request must hold through wait states, and no start may be accepted while busy.

Other behaviours only the directed scenarios can show. These are the sign extension of the 5- and 9-bit fields with junk in the upper offset bits, the zero extension of the accumulators, wrap-around, and the exact assembled indirect word.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  parameter int unsigned AW    = 16;
  parameter int unsigned BW    = AW / 2;
  parameter int unsigned ACCW  = 8;
  parameter int unsigned STEPW = 3;
  parameter int unsigned SW5   = 5;
  parameter int unsigned SW9   = 9;

  typedef logic [AW-1:0] addr_t;

  typedef enum logic [3:0] {
    M_CONST5   = 4'd0,
    M_CONST9   = 4'd1,
    M_CONST16  = 4'd2,
    M_ACC_A    = 4'd3,
    M_ACC_B    = 4'd4,
    M_ACC_D    = 4'd5,
    M_PRE_INC  = 4'd6,
    M_PRE_DEC  = 4'd7,
    M_POST_INC = 4'd8,
    M_POST_DEC = 4'd9,
    M_IND_K    = 4'd10,
    M_IND_D    = 4'd11
  } idx_mode_e;

  typedef enum logic [1:0] {
    SEL_X  = 2'd0,
    SEL_Y  = 2'd1,
    SEL_SP = 2'd2,
    SEL_PC = 2'd3
  } base_sel_e;

  // sign-extend the low w bits of raw to the full address width
  function automatic addr_t f_sext(input addr_t raw, input int unsigned w);
    addr_t res;
    for (int i = 0; i < int'(AW); i++)
      res[i] = (i < int'(w)) ? raw[i] : raw[w-1];
    return res;
  endfunction

  // step code 0..7 encodes an adjustment of 1..8
  function automatic addr_t f_step(input logic [STEPW-1:0] code);
    return addr_t'(code) + addr_t'(1);
  endfunction

  function automatic addr_t f_zext(input logic [ACCW-1:0] v);
    return addr_t'(v);
  endfunction

  function automatic logic f_is_auto(input logic [3:0] m);
    return (m >= 4'd6) && (m <= 4'd9);
  endfunction
endpackage

// File: rtl/idx_off_calc.sv
module idx_off_calc
  import idx_ea_pkg::*;
(
  input  logic [3:0]      mode,
  input  addr_t           offset,
  input  logic [ACCW-1:0] acc_a,
  input  logic [ACCW-1:0] acc_b,
  output addr_t           off_val,
  output addr_t           step,
  output logic            is_auto,
  output logic            is_pre,
  output logic            is_dec,
  output logic            is_ind,
  output logic            reserved
);
  idx_mode_e m;
  addr_t     acc_d;

  assign m     = idx_mode_e'(mode);
  assign acc_d = {acc_a, acc_b};
  assign step  = f_step(offset[STEPW-1:0]);

  always_comb begin
    off_val  = '0;
    is_auto  = 1'b0;
    is_pre   = 1'b0;
    is_dec   = 1'b0;
    is_ind   = 1'b0;
    reserved = 1'b0;
    case (m)
      M_CONST5:   off_val = f_sext(offset, SW5);
      M_CONST9:   off_val = f_sext(offset, SW9);
      M_CONST16:  off_val = offset;
      M_ACC_A:    off_val = f_zext(acc_a);
      M_ACC_B:    off_val = f_zext(acc_b);
      M_ACC_D:    off_val = acc_d;
      M_PRE_INC:  begin is_auto = 1'b1; is_pre = 1'b1; end
      M_PRE_DEC:  begin is_auto = 1'b1; is_pre = 1'b1; is_dec = 1'b1; end
      M_POST_INC: is_auto = 1'b1;
      M_POST_DEC: begin is_auto = 1'b1; is_dec = 1'b1; end
      M_IND_K:    begin off_val = offset; is_ind = 1'b1; end
      M_IND_D:    begin off_val = acc_d;  is_ind = 1'b1; end
      default:    reserved = 1'b1;
    endcase
  end
endmodule

// File: rtl/idx_fetch_seq.sv
module idx_fetch_seq
  import idx_ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  addr_t         ptr_in,
  input  logic          mem_valid,
  input  logic [BW-1:0] mem_rdata,
  output logic          mem_req,
  output addr_t         mem_addr,
  output logic          idle,
  output logic          lo_phase,
  output logic          fin,
  output addr_t         word
);
  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} fst_e;

  fst_e          st_q;
  addr_t         ptr_q;
  logic [BW-1:0] hi_q;

  assign idle     = (st_q == S_IDLE);
  assign lo_phase = (st_q == S_LO);
  assign mem_req  = !idle;
  assign mem_addr = lo_phase ? (ptr_q + addr_t'(1)) : ptr_q;
  assign fin      = lo_phase && mem_valid;
  assign word     = {hi_q, mem_rdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ptr_q <= '0;
      hi_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (launch) begin
          ptr_q <= ptr_in;
          st_q  <= S_HI;
        end
        S_HI: if (mem_valid) begin
          hi_q <= mem_rdata;
          st_q <= S_LO;
        end
        S_LO: if (mem_valid) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       mode,
  input  logic [1:0]       base_sel,
  input  logic [AW-1:0]    reg_x,
  input  logic [AW-1:0]    reg_y,
  input  logic [AW-1:0]    reg_sp,
  input  logic [AW-1:0]    reg_pc,
  input  logic [AW-1:0]    offset,
  input  logic [ACCW-1:0]  acc_a,
  input  logic [ACCW-1:0]  acc_b,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_valid,
  input  logic [BW-1:0]    mem_rdata,
  output logic             done,
  output logic [AW-1:0]    ea,
  output logic             wb_en,
  output logic [AW-1:0]    wb_value,
  output logic             illegal,
  output logic             indirect
);
  localparam int unsigned NBASE = 4;

  addr_t             base_bank [NBASE];
  addr_t             base_val;
  addr_t             off_val, step, adj_up, adj_dn, adj_val;
  addr_t             addr_calc, wb_calc, seq_word;
  logic              is_auto, is_pre, is_dec, is_ind, reserved;
  logic              illegal_calc, accept, seq_idle, seq_lo, seq_fin;

  addr_t             ea_q, wb_val_q;
  logic              done_q, wb_en_q, illegal_q, ind_done_q;

  assign base_bank[SEL_X]  = reg_x;
  assign base_bank[SEL_Y]  = reg_y;
  assign base_bank[SEL_SP] = reg_sp;
  assign base_bank[SEL_PC] = reg_pc;
  assign base_val          = base_bank[base_sel];

  idx_off_calc u_off (
    .mode(mode), .offset(offset), .acc_a(acc_a), .acc_b(acc_b),
    .off_val(off_val), .step(step), .is_auto(is_auto), .is_pre(is_pre),
    .is_dec(is_dec), .is_ind(is_ind), .reserved(reserved)
  );

  assign adj_up  = base_val + step;
  assign adj_dn  = base_val - step;
  assign adj_val = is_dec ? adj_dn : adj_up;

  always_comb begin
    if (is_auto) addr_calc = is_pre ? adj_val : base_val;
    else         addr_calc = base_val + off_val;
  end
  assign wb_calc = adj_val;

  assign illegal_calc = reserved || (is_auto && (base_sel == SEL_PC));
  assign accept       = start && seq_idle;

  idx_fetch_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(accept && is_ind), .ptr_in(addr_calc),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .idle(seq_idle), .lo_phase(seq_lo), .fin(seq_fin),
    .word(seq_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      wb_en_q    <= 1'b0;
      illegal_q  <= 1'b0;
      ind_done_q <= 1'b0;
      ea_q       <= '0;
      wb_val_q   <= '0;
    end else begin
      done_q     <= 1'b0;
      wb_en_q    <= 1'b0;
      illegal_q  <= 1'b0;
      ind_done_q <= 1'b0;
      if (accept && !is_ind) begin
        done_q    <= 1'b1;
        ea_q      <= addr_calc;
        wb_en_q   <= is_auto && !illegal_calc;
        wb_val_q  <= wb_calc;
        illegal_q <= illegal_calc;
      end
      if (seq_fin) begin
        done_q     <= 1'b1;
        ea_q       <= seq_word;
        ind_done_q <= 1'b1;
      end
    end
  end

  assign done     = done_q;
  assign ea       = ea_q;
  assign wb_en    = wb_en_q;
  assign wb_value = wb_val_q;
  assign illegal  = illegal_q;
  assign indirect = !seq_idle || ind_done_q;
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk
  import idx_ea_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic [3:0]    mode,
  input logic [1:0]    base_sel,
  input logic [AW-1:0] base_val,
  input logic          done,
  input logic [AW-1:0] ea,
  input logic          wb_en,
  input logic [AW-1:0] wb_value,
  input logic          illegal,
  input logic          indirect,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic          seq_lo
);
  logic is_post, is_pre, on_pc;
  assign is_post = (mode == M_POST_INC) || (mode == M_POST_DEC);
  assign is_pre  = (mode == M_PRE_INC)  || (mode == M_PRE_DEC);
  assign on_pc   = (base_sel == SEL_PC);

  a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || illegal) |-> done);

  a_r2_direct_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode != M_IND_K && mode != M_IND_D) |=> (done && !indirect));

  a_r4_pre_wb_is_ea: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_pre && !on_pc) |=> (wb_en && wb_value == ea));

  a_r5_post_ea_is_base: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_post && !on_pc) |=> (wb_en && ea == $past(base_val)));

  a_r7_pc_auto_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (is_pre || is_post) && on_pc) |=> (illegal && !wb_en));

  a_r8_lo_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !seq_lo) |=>
      (mem_req && seq_lo && mem_addr == $past(mem_addr) + 16'd1));

  a_r8_done_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && seq_lo) |=> (done && indirect && !mem_req));

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !accept);

  a_r10_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

bind idx_ea_gen idx_ea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .mode(mode), .base_sel(base_sel),
  .base_val(base_val), .done(done), .ea(ea), .wb_en(wb_en),
  .wb_value(wb_value), .illegal(illegal), .indirect(indirect),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .seq_lo(seq_lo)
);

// File: tb/test_idx_ea_gen.sv
module test_idx_ea_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  base_sel = '0;
  logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3FF0, reg_pc = 16'hC000;
  logic [15:0] offset = '0;
  logic [7:0]  acc_a = 8'h80, acc_b = 8'hFF;
  logic        mem_req, mem_valid = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done, wb_en, illegal, indirect;
  logic [15:0] ea, wb_value;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_gen i_idx_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_sel(base_sel),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .offset(offset), .acc_a(acc_a), .acc_b(acc_b), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .done(done), .ea(ea), .wb_en(wb_en), .wb_value(wb_value),
    .illegal(illegal), .indirect(indirect)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // direct forms: start at a negedge, result one edge later
  task automatic t_direct(input string req, input int m, input int sel, input int off,
                          input int exp_ea, input int exp_wb_en, input int exp_wb,
                          input int exp_ill);
    mode = 4'(m); base_sel = 2'(sel); offset = 16'(off); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, "done", int'(done), 1);
    chk(req, "illegal", int'(illegal), exp_ill);
    chk(req, "wb_en", int'(wb_en), exp_wb_en);
    chk(req, "indirect", int'(indirect), 0);
    if (exp_ill == 0) chk(req, "ea", int'(ea), exp_ea);
    if (exp_wb_en != 0) chk(req, "wb_value", int'(wb_value), exp_wb);
    @(negedge clk);
    chk(req, "done pulse ends", int'(done), 0);
  endtask

  task automatic t_indirect(input string req, input int m, input int sel, input int off,
                            input int ptr, input int hi, input int lo,
                            input int waits, input bit poke_start);
    mode = 4'(m); base_sel = 2'(sel); offset = 16'(off); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, "hi req", int'(mem_req), 1);
    chk(req, "hi addr", int'(mem_addr), ptr);
    chk(req, "indirect busy", int'(indirect), 1);
    chk(req, "no early done", int'(done), 0);
    for (int w = 0; w < waits; w++) begin
      if (poke_start && w == 0) begin
        mode = 4'd2; base_sel = 2'd0; offset = 16'h0004; start = 1'b1;   // R9
      end
      @(negedge clk);
      start = 1'b0;
      chk("R10", "hi addr held", int'(mem_addr), ptr);
      chk("R9", "no done while busy", int'(done), 0);
      chk("R10", "req held", int'(mem_req), 1);
    end
    mem_valid = 1'b1; mem_rdata = 8'(hi);
    @(negedge clk);
    chk(req, "lo addr", int'(mem_addr), (ptr + 1) & 16'hFFFF);
    chk(req, "no done after hi", int'(done), 0);
    mem_rdata = 8'(lo);
    @(negedge clk);
    mem_valid = 1'b0;
    chk(req, "done", int'(done), 1);
    chk(req, "indirect with done", int'(indirect), 1);
    chk(req, "ea word", int'(ea), (hi << 8) | lo);
    chk(req, "no wb", int'(wb_en), 0);
    chk(req, "req drops", int'(mem_req), 0);
    @(negedge clk);
    chk(req, "indirect clears", int'(indirect), 0);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", int'(done), 0);
    chk("R1", "mem_req", int'(mem_req), 0);
    chk("R1", "wb_en|illegal|indirect", int'({wb_en, illegal, indirect}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done idle", int'(done), 0);

    // R2 / R3 constant offsets, upper junk ignored
    t_direct("R2", 0, 0, 16'hABD0, 16'h0FF0, 0, 0, 0);
    t_direct("R2", 0, 1, 16'h000F, 16'h200F, 0, 0, 0);
    t_direct("R2", 1, 2, 16'h0100, 16'h3EF0, 0, 0, 0);
    t_direct("R2", 1, 2, 16'hFEFF, 16'h40EF, 0, 0, 0);
    t_direct("R3", 2, 3, 16'h8000, 16'h4000, 0, 0, 0);
    t_direct("R2", 2, 3, 16'h5000, 16'h1000, 0, 0, 0);
    // R6 accumulator offsets
    t_direct("R6", 3, 0, 0, 16'h1080, 0, 0, 0);
    t_direct("R6", 4, 1, 0, 16'h20FF, 0, 0, 0);
    t_direct("R6", 5, 2, 0, 16'hC0EF, 0, 0, 0);
    // R4 pre forms
    t_direct("R4", 6, 0, 16'hFFF7, 16'h1008, 1, 16'h1008, 0);
    t_direct("R4", 7, 2, 16'h0000, 16'h3FEF, 1, 16'h3FEF, 0);
    // R5 post forms
    t_direct("R5", 8, 1, 16'h0002, 16'h2000, 1, 16'h2003, 0);
    t_direct("R5", 9, 0, 16'h0007, 16'h1000, 1, 16'h0FF8, 0);
    // R7 illegal combinations
    t_direct("R7", 6, 3, 16'h0001, 0, 0, 0, 1);
    t_direct("R7", 9, 3, 16'h0001, 0, 0, 0, 1);
    t_direct("R7", 13, 0, 16'h0001, 0, 0, 0, 1);
    // R8 indirect, R9 / R10 during waits
    t_indirect("R8", 10, 0, 16'hFFFE, 16'h0FFE, 8'h12, 8'h34, 0, 0);
    t_indirect("R8", 11, 1, 16'h0000, 16'hA0FF, 8'hBE, 8'hEF, 3, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule